// File: doc/BRIEF.md
# Power-Good Supervisor

This block sets the level of a single power-good flag for a regulator. Its inputs are clean, synchronous, active-high flags from comparators elsewhere on the chip: output under-voltage trip, output over-voltage trip, output inside its regulation window (hysteresis already applied), thermal trip and thermal clear, enable above its rising threshold, enable below its falling threshold, and current limit active. The output `pgood` is high when the open-drain power-good pin would be released.

Over- and under-voltage excursions must persist for a programmable number of clock cycles before they count as faults, so line and load transients do not pull the flag. Each fault kind has its own end condition. Once every fault has ended, a release timer must run out before the flag rises. The first rise after reset uses a longer start-up delay, which by default is 6 ms at the configured clock. Enable dropping below its falling threshold forces the flag low at once.

Top module: `pgood_supervisor`

## Requirements
- R1: While `rst` is high, and after it is released, `pgood` is low and the block is disabled; it stays low until `en_above` is sampled high with `en_below` low.
- R2: On the first enable after reset, with the output in regulation and no fault, `pgood` rises on the START_CYC-th clock edge after the edge that samples `en_above` high.
- R3: `en_below` high drives `pgood` low in the same cycle, without waiting for a clock edge; the block then stays disabled, with `pgood` low, until `en_above` is sampled high again.
- R4: `uv_trip` sampled high on FILT_CYC-1 consecutive edges leaves `pgood` high; sampled high on FILT_CYC consecutive edges, `pgood` is low after the FILT_CYC-th edge.
- R5: `ov_trip` is filtered the same way, and a single low sample clears either filter count, so two short excursions separated by one low cycle never add up to a fault.
- R6: A voltage fault ends only once its trip input is low and `in_reg` is high; `pgood` then rises on the REL_CYC-th edge after the edge that first samples that end condition.
- R7: `tsd_trip` high pulls `pgood` low after the next edge; the thermal fault ends only when `tsd_clear` and `in_reg` are both sampled high, after which the REL_CYC release delay applies.
- R8: `ilim_active` high pulls `pgood` low after the next edge and holds it low; once it drops with `in_reg` high, the REL_CYC release delay applies.
- R9: A qualified voltage fault, `tsd_trip` or `ilim_active` arriving while the release delay runs cancels it; the next release needs a full REL_CYC delay again.
- R10: Re-enabling after the start-up delay has completed once uses the REL_CYC delay, not START_CYC.
- R11: If the start-up delay expires while the output is out of regulation or a fault is present, `pgood` stays low, and it rises REL_CYC edges after the fault ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_above | input | 1 | Enable is above its rising threshold |
| en_below | input | 1 | Enable is below its falling threshold |
| uv_trip | input | 1 | Output under-voltage comparator tripped |
| ov_trip | input | 1 | Output over-voltage comparator tripped |
| in_reg | input | 1 | Output inside the regulation window with hysteresis |
| tsd_trip | input | 1 | Junction temperature above thermal trip |
| tsd_clear | input | 1 | Junction temperature below trip minus hysteresis |
| ilim_active | input | 1 | Current limit active |
| pgood | output | 1 | High when the power-good pin is released |

## Verification
A supervisor stuck in the wrong state shows up directly on `pgood`. A timer that is loaded or compared wrongly moves the rising edge by one or more cycles, so every release is checked both on the edge before the expected rise and on the rise itself. A filter count that is not cleared, or that stops one short, turns glitch pulses into faults within FILT_CYC cycles. A fault flag latched in the wrong place lets the flag rise while a thermal or regulation condition still holds it down, and that is visible on the first edge after the release delay.

// File: rtl/pgood_pkg.sv
package pgood_pkg;

    typedef enum logic [2:0] {
        PG_OFF   = 3'd0,
        PG_BOOT  = 3'd1,
        PG_FAULT = 3'd2,
        PG_HOLD  = 3'd3,
        PG_GOOD  = 3'd4
    } pg_state_e;

    typedef struct packed {
        pg_state_e state;
        logic      started;
        logic      uv_f;
        logic      ov_f;
        logic      tsd_f;
    } pg_regs_t;

endpackage

// File: rtl/pgood_glitch_filter.sv
module pgood_glitch_filter #(
    parameter int FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic trip,
    output logic qual
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] LAST = FW'(FILT_CYC - 1);

    logic [FW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!trip)
            cnt_d = '0;
        else if (cnt_q != LAST)
            cnt_d = cnt_q + 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign qual = trip && (cnt_q == LAST);

    generate
        if (FILT_CYC > 1) begin : g_chk
            // R4, R5: a qualified fault never appears without a prior high sample
            a_r4_needs_history: assert property (@(posedge clk) disable iff (rst)
                qual |-> $past(trip));
            // R5: a low sample clears the count
            a_r5_low_clears: assert property (@(posedge clk) disable iff (rst)
                !trip |=> !qual);
        end
    endgenerate

endmodule

// File: rtl/pgood_timer.sv
module pgood_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6: the delay advances by exactly one per cycle while running
    a_r6_step_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> cnt_q == TW'($past(cnt_q) - 1'b1));

endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
    import pgood_pkg::*;
#(
    parameter int CLK_HZ    = 50_000_000,
    parameter int FILT_CYC  = 16,
    parameter int REL_CYC   = 1000,
    parameter int START_CYC = CLK_HZ / 1000 * 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en_above,
    input  logic en_below,
    input  logic uv_trip,
    input  logic ov_trip,
    input  logic in_reg,
    input  logic tsd_trip,
    input  logic tsd_clear,
    input  logic ilim_active,
    output logic pgood
);
    localparam int MAXC = (START_CYC > REL_CYC) ? START_CYC : REL_CYC;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] START_LD = TW'(START_CYC - 1);
    localparam logic [TW-1:0] REL_LD   = TW'(REL_CYC - 1);

    // voltage fault qualification, one filter per comparator
    logic [1:0] trip_v, qual_v;
    assign trip_v = {ov_trip, uv_trip};

    generate
        for (genvar gi = 0; gi < 2; gi++) begin : g_filt
            pgood_glitch_filter #(.FILT_CYC(FILT_CYC)) u_filt (
                .clk  (clk),
                .rst  (rst),
                .trip (trip_v[gi]),
                .qual (qual_v[gi])
            );
        end
    endgenerate

    logic uv_q, ov_q;
    assign uv_q = qual_v[0];
    assign ov_q = qual_v[1];

    // shared start-up / release delay
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_exp;

    pgood_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    pg_regs_t r_d, r_q;
    logic     new_fault;
    logic     blocked;

    always_comb begin
        r_d       = r_q;
        t_load    = 1'b0;
        t_val     = REL_LD;
        new_fault = uv_q || ov_q || tsd_trip || ilim_active;

        // faults latch in every enabled state
        r_d.uv_f  = r_q.uv_f  || uv_q;
        r_d.ov_f  = r_q.ov_f  || ov_q;
        r_d.tsd_f = r_q.tsd_f || tsd_trip;
        blocked   = r_d.uv_f || r_d.ov_f || r_d.tsd_f || ilim_active || !in_reg;

        case (r_q.state)
            PG_OFF: begin
                r_d.uv_f  = 1'b0;
                r_d.ov_f  = 1'b0;
                r_d.tsd_f = 1'b0;
                if (en_above) begin
                    if (!r_q.started) begin
                        r_d.state = PG_BOOT;
                        t_load    = 1'b1;
                        t_val     = START_LD;
                    end else if (in_reg && !new_fault) begin
                        r_d.state = PG_HOLD;
                        t_load    = 1'b1;
                    end else begin
                        r_d.state = PG_FAULT;
                        r_d.uv_f  = uv_q;
                        r_d.ov_f  = ov_q;
                        r_d.tsd_f = tsd_trip;
                    end
                end
            end
            PG_BOOT: begin
                if (t_exp) begin
                    r_d.started = 1'b1;
                    r_d.state   = blocked ? PG_FAULT : PG_GOOD;
                end
            end
            PG_FAULT: begin
                if (in_reg) begin
                    r_d.uv_f = uv_q;
                    r_d.ov_f = ov_q;
                    if (tsd_clear && !tsd_trip)
                        r_d.tsd_f = 1'b0;
                end
                if (in_reg && !ilim_active && !r_d.uv_f && !r_d.ov_f && !r_d.tsd_f) begin
                    r_d.state = PG_HOLD;
                    t_load    = 1'b1;
                end
            end
            PG_HOLD: begin
                if (new_fault)
                    r_d.state = PG_FAULT;
                else if (t_exp)
                    r_d.state = PG_GOOD;
            end
            PG_GOOD: begin
                if (new_fault)
                    r_d.state = PG_FAULT;
            end
            default: r_d.state = PG_OFF;
        endcase

        // enable fault has top priority
        if (en_below) begin
            r_d.state = PG_OFF;
            t_load    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.state   <= PG_OFF;
            r_q.started <= 1'b0;
            r_q.uv_f    <= 1'b0;
            r_q.ov_f    <= 1'b0;
            r_q.tsd_f   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // enable-low gate is combinational: no cycle of delay
    assign pgood = (r_q.state == PG_GOOD) && !en_below;

    // R1: flag low straight out of reset
    a_r1_reset_low: assert property (@(posedge clk)
        rst |=> !pgood);
    // R3: enable fault disables the block
    a_r3_en_off: assert property (@(posedge clk) disable iff (rst)
        en_below |=> (!pgood && r_q.state == PG_OFF));
    // R8: current limit holds the flag low
    a_r8_ilim_low: assert property (@(posedge clk) disable iff (rst)
        ilim_active |=> !pgood);
    // R7: thermal trip pulls the flag low
    a_r7_tsd_low: assert property (@(posedge clk) disable iff (rst)
        tsd_trip |=> !pgood);
    // R7: thermal fault needs its clear input before release starts
    a_r7_tsd_hold: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == PG_FAULT && r_q.tsd_f && !tsd_clear) |=> r_q.state != PG_HOLD);
    // R6: no release while out of regulation
    a_r6_needs_reg: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == PG_FAULT && !in_reg) |=> r_q.state != PG_HOLD);
    // R2, R6: the good state is only entered when a delay has run out
    a_r6_good_after_timer: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == PG_GOOD && $past(r_q.state) != PG_GOOD)
            |-> ($past(t_exp) && ($past(r_q.state) == PG_HOLD || $past(r_q.state) == PG_BOOT)));
    // R9: a fault during release cancels it
    a_r9_cancel: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == PG_HOLD && ilim_active) |=> r_q.state != PG_GOOD);

endmodule

// File: tb/sim_pgood_supervisor.sv
module sim_pgood_supervisor;
    localparam int FILT  = 4;
    localparam int REL   = 10;
    localparam int START = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_above = 1'b0, en_below = 1'b0, uv_trip = 1'b0, ov_trip = 1'b0;
    logic in_reg = 1'b1, tsd_trip = 1'b0, tsd_clear = 1'b1, ilim_active = 1'b0;
    logic pgood;

    int total = 0;
    int bad   = 0;
    bit fin   = 1'b0;

    always #10 clk = ~clk;

    pgood_supervisor #(
        .CLK_HZ(50_000_000), .FILT_CYC(FILT), .REL_CYC(REL), .START_CYC(START)
    ) u0 (
        .clk(clk), .rst(rst), .en_above(en_above), .en_below(en_below),
        .uv_trip(uv_trip), .ov_trip(ov_trip), .in_reg(in_reg),
        .tsd_trip(tsd_trip), .tsd_clear(tsd_clear), .ilim_active(ilim_active),
        .pgood(pgood)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic exp, input string tag);
        total++;
        if (pgood !== exp) begin
            bad++;
            $display("FAIL %s: pgood=%b expected=%b", tag, pgood, exp);
        end
    endtask

    // release condition driven at this negedge; rise on the REL-th edge after
    task automatic rel_check(input string tag);
        step(REL);
        chk(1'b0, {tag, " before release"});
        step(1);
        chk(1'b1, {tag, " at release"});
    endtask

    task automatic t_reset;
        step(3);
        chk(1'b0, "R1 during reset");
        rst = 1'b0;
        step(5);
        chk(1'b0, "R1 after reset, not enabled");
    endtask

    task automatic t_startup;
        en_above = 1'b1;
        step(START);
        chk(1'b0, "R2 one edge before start-up end");
        step(1);
        chk(1'b1, "R2 start-up end");
    endtask

    task automatic t_glitch;
        uv_trip = 1'b1;
        step(FILT - 1);
        uv_trip = 1'b0;
        chk(1'b1, "R4 short uv excursion");
        step(1);
        uv_trip = 1'b1;
        step(FILT - 1);
        uv_trip = 1'b0;
        step(2);
        chk(1'b1, "R5 count cleared between uv pulses");
        ov_trip = 1'b1;
        step(FILT - 1);
        ov_trip = 1'b0;
        step(2);
        chk(1'b1, "R5 short ov excursion");
    endtask

    task automatic t_uv;
        uv_trip = 1'b1;
        in_reg  = 1'b0;
        step(FILT - 1);
        chk(1'b1, "R4 uv one sample short");
        step(1);
        chk(1'b0, "R4 uv qualified");
        uv_trip = 1'b0;
        step(20);
        chk(1'b0, "R6 out of regulation holds fault");
        in_reg = 1'b1;
        rel_check("R6 uv release");
    endtask

    task automatic t_ov;
        ov_trip = 1'b1;
        in_reg  = 1'b0;
        step(FILT);
        chk(1'b0, "R5 ov qualified");
        ov_trip = 1'b0;
        in_reg  = 1'b1;
        rel_check("R5 ov release");
    endtask

    task automatic t_tsd;
        tsd_clear = 1'b0;
        tsd_trip  = 1'b1;
        step(1);
        chk(1'b0, "R7 thermal trip");
        tsd_trip  = 1'b0;
        tsd_clear = 1'b1;
        in_reg    = 1'b0;
        step(20);
        chk(1'b0, "R7 clear without regulation");
        in_reg    = 1'b1;
        tsd_clear = 1'b0;
        step(20);
        chk(1'b0, "R7 regulation without clear");
        tsd_clear = 1'b1;
        rel_check("R7 thermal release");
    endtask

    task automatic t_ilim;
        ilim_active = 1'b1;
        step(1);
        chk(1'b0, "R8 current limit");
        step(20);
        chk(1'b0, "R8 current limit held");
        ilim_active = 1'b0;
        rel_check("R8 current limit release");
    endtask

    task automatic t_reassert;
        ilim_active = 1'b1;
        step(2);
        ilim_active = 1'b0;
        step(REL / 2);
        chk(1'b0, "R9 mid release");
        ilim_active = 1'b1;
        step(1);
        ilim_active = 1'b0;
        rel_check("R9 restarted release");
    endtask

    task automatic t_enable;
        en_below = 1'b1;
        en_above = 1'b0;
        #1;
        chk(1'b0, "R3 immediate enable low");
        step(5);
        en_below = 1'b0;
        step(5);
        chk(1'b0, "R3 stays disabled");
        en_above = 1'b1;
        rel_check("R10 re-enable uses release delay");
    endtask

    task automatic t_boot_blocked;
        rst      = 1'b1;
        en_above = 1'b0;
        step(2);
        rst      = 1'b0;
        in_reg   = 1'b0;
        en_above = 1'b1;
        step(START + 1);
        chk(1'b0, "R11 start-up ends out of regulation");
        step(10);
        chk(1'b0, "R11 still out of regulation");
        in_reg = 1'b1;
        rel_check("R11 release after blocked start-up");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_startup();
        t_glitch();
        t_uv();
        t_ov();
        t_tsd();
        t_ilim();
        t_reassert();
        t_enable();
        t_boot_blocked();
        fin = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: state=hung expected=complete");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule